// File: doc/BRIEF.md
# Feedback Control-Point and Observation Compaction Wrapper

This block wraps the feedback lines and hard-to-observe nets of a self-timed handshake pipeline so that a clocked scan test flow can control and observe them. Each completion feedback line that runs from a later stage back to an earlier register passes through an XOR gate. The other input of that gate is a per-line test-control bit. While the control bit is 0, the line passes through unchanged, so functional operation is not affected. During test, the tester drives the control bit to force or invert the value that comes back.

A group of internal nets that cannot otherwise be seen is compacted into a single observation output, with no extra pin for each net. One of two paths is chosen by a mode input. The first is a balanced XOR tree whose parity result is registered. The second splits the nets into groups of four. Each group feeds a NAND gate, and each NAND output feeds a scannable observation flop. These flops form one shift chain with its own scan input. They capture when scan enable is low and shift when it is high.

The feedback path through the wrapper is purely combinational. Only the observation side uses the clock.

Top module: `fb_testpoint_wrap`

## Requirements
- R1: Each feedback output bit `fb_out[i]` equals `fb_in[i] XOR tc[i]` in the same cycle, with no clock involved.
- R2: With `tc` all zero, `fb_out` equals `fb_in` whatever the observation inputs, mode and scan controls do.
- R3: With `obs_mode`=0, `obs_out` shows the XOR of all `NUM_OBS` bits of `obs_nets` sampled at the previous rising clock edge.
- R4: With `obs_mode`=1 and `scan_en`=0, at each rising edge observation flop g captures the NAND of `obs_nets[4g+3:4g]`. Flop 0 takes nets 3..0.
- R5: In the last group, positions beyond `NUM_OBS-1` act as constant 1. With the default of 10 nets, the last flop captures NAND(net9, net8, 1, 1).
- R6: With `obs_mode`=1 and `scan_en`=1, the chain shifts at each rising edge. `scan_in` enters flop 0 and flop g moves to flop g+1. `obs_out` shows the last flop, so the last group leaves first.
- R7: While `obs_mode`=0, the observation flops hold their contents regardless of `scan_en`, `scan_in` and `obs_nets`.
- R8: While `rst` is high at a rising edge, the parity register and all observation flops clear to 0. After reset `obs_out` reads 0 in both modes.
- R9: `obs_out` follows a change of `obs_mode` in the same cycle. It selects the registered parity (0) or the last chain flop (1), and no clock edge is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test/observation clock |
| rst | input | 1 | Synchronous active-high reset of the observation state |
| fb_in | input | NUM_FB | Completion feedback lines entering the wrapper |
| tc | input | NUM_FB | Per-line test-control bits, 0 in functional mode |
| fb_out | output | NUM_FB | Feedback lines delivered back to the pipeline registers |
| obs_nets | input | NUM_OBS | Internal nets to be made observable |
| obs_mode | input | 1 | 0 selects the XOR-tree path, 1 selects the NAND flop chain |
| scan_en | input | 1 | 1 shifts the observation chain, 0 captures |
| scan_in | input | 1 | Serial input of the observation chain |
| obs_out | output | 1 | Single observation output |

## Verification
The XOR-tree path is tried with all-zero and all-one nets and with a walking one across every net. The walking one shows that each net reaches the tree and that no net is dropped or duplicated. The chain is loaded with all-ones nets, which tells a correct constant-1 pad in the last group apart from a constant-0 pad. It is also loaded with all-zeros and random patterns and then shifted out, which shows the group order and shift direction. A capture, followed by a long stretch in tree mode with scan enable toggling, followed by a shift-out, shows that the chain holds its contents. Random feedback values are tried with the control bits cleared and with them random, and mode is toggled at random on every cycle, which shows the combinational output select.

// File: rtl/fbw_pkg.sv
package fbw_pkg;
  // Width of one NAND compaction group
  localparam int unsigned GROUP_W = 4;

  // Observation path selector values
  typedef enum logic {
    OBS_TREE  = 1'b0,
    OBS_CHAIN = 1'b1
  } obs_sel_e;

  function automatic int unsigned num_groups(input int unsigned nets);
    return (nets + GROUP_W - 1) / GROUP_W;
  endfunction
endpackage

// File: rtl/fb_ctl_points.sv
module fb_ctl_points #(
  parameter int unsigned NUM_FB = 6
) (
  input  logic [NUM_FB-1:0] fb_in,
  input  logic [NUM_FB-1:0] tc,
  output logic [NUM_FB-1:0] fb_out
);
  // One XOR control point per feedback line
  for (genvar i = 0; i < NUM_FB; i++) begin : g_cp
    assign fb_out[i] = fb_in[i] ^ tc[i];
  end
endmodule

// File: rtl/obs_xor_tree.sv
module obs_xor_tree #(
  parameter int unsigned N = 10
) (
  input  logic [N-1:0] leaves,
  output logic         root
);
  localparam int unsigned DEPTH = $clog2(N);
  localparam int unsigned PADN  = 1 << DEPTH;

  // Heap-ordered node array: node n has children 2n and 2n+1
  logic [2*PADN-1:0] nd;

  assign nd[0] = 1'b0;

  for (genvar i = 0; i < PADN; i++) begin : g_leaf
    if (i < N) begin : g_real
      assign nd[PADN+i] = leaves[i];
    end else begin : g_pad
      assign nd[PADN+i] = 1'b0;
    end
  end

  for (genvar n = 1; n < PADN; n++) begin : g_node
    assign nd[n] = nd[2*n] ^ nd[2*n+1];
  end

  assign root = nd[1];
endmodule

// File: rtl/nand_obs_chain.sv
module nand_obs_chain
  import fbw_pkg::*;
#(
  parameter int unsigned N = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     enable,
  input  logic                     shift,
  input  logic                     sin,
  input  logic [N-1:0]             nets,
  output logic [num_groups(N)-1:0] chain_q
);
  localparam int unsigned NG   = num_groups(N);
  localparam int unsigned PADW = NG * GROUP_W;

  logic [PADW-1:0] padded;
  logic [NG-1:0]   grp_nand;
  logic [NG:0]     shl;

  if (PADW > N) begin : g_pad
    assign padded = {{(PADW-N){1'b1}}, nets};
  end else begin : g_nopad
    assign padded = nets;
  end

  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign grp_nand[g] = ~&padded[g*GROUP_W +: GROUP_W];
  end

  assign shl = {chain_q, sin};

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
    end else if (enable) begin
      if (shift) chain_q <= shl[NG-1:0];
      else       chain_q <= grp_nand;
    end
  end
endmodule

// File: rtl/fb_testpoint_wrap.sv
module fb_testpoint_wrap
  import fbw_pkg::*;
#(
  parameter int unsigned NUM_FB  = 6,
  parameter int unsigned NUM_OBS = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_FB-1:0]  fb_in,
  input  logic [NUM_FB-1:0]  tc,
  output logic [NUM_FB-1:0]  fb_out,
  input  logic [NUM_OBS-1:0] obs_nets,
  input  logic               obs_mode,
  input  logic               scan_en,
  input  logic               scan_in,
  output logic               obs_out
);
  localparam int unsigned NUM_GRP = num_groups(NUM_OBS);

  obs_sel_e           sel;
  logic               tree_root;
  logic               par_q;
  logic [NUM_GRP-1:0] chain_q;

  assign sel = obs_sel_e'(obs_mode);

  fb_ctl_points #(.NUM_FB(NUM_FB)) u_cp (
    .fb_in  (fb_in),
    .tc     (tc),
    .fb_out (fb_out)
  );

  obs_xor_tree #(.N(NUM_OBS)) u_tree (
    .leaves (obs_nets),
    .root   (tree_root)
  );

  always_ff @(posedge clk) begin
    if (rst) par_q <= 1'b0;
    else     par_q <= tree_root;
  end

  nand_obs_chain #(.N(NUM_OBS)) u_chain (
    .clk     (clk),
    .rst     (rst),
    .enable  (sel == OBS_CHAIN),
    .shift   (scan_en),
    .sin     (scan_in),
    .nets    (obs_nets),
    .chain_q (chain_q)
  );

  assign obs_out = (sel == OBS_CHAIN) ? chain_q[NUM_GRP-1] : par_q;
endmodule

// File: rtl/fbw_checker.sv
module fbw_checker #(
  parameter int unsigned NF = 6,
  parameter int unsigned K  = 10,
  parameter int unsigned NG = 3
) (
  input logic          clk,
  input logic          rst,
  input logic [NF-1:0] fb_in,
  input logic [NF-1:0] tc,
  input logic [NF-1:0] fb_out,
  input logic [K-1:0]  obs_nets,
  input logic          obs_mode,
  input logic          scan_en,
  input logic          scan_in,
  input logic          obs_out,
  input logic [NG-1:0] chain_q
);
  logic [NG:0] shl;
  assign shl = {chain_q, scan_in};

  // R1
  fb_cp_xor_chk: assert property (@(posedge clk) disable iff (rst)
    (fb_out ^ fb_in) == tc);

  // R2
  fb_transparent_chk: assert property (@(posedge clk) disable iff (rst)
    (tc == '0) |-> (fb_out == fb_in));

  // R3
  tree_parity_chk: assert property (@(posedge clk) disable iff (rst)
    (!obs_mode && !$past(rst)) |-> (obs_out == ^$past(obs_nets)));

  // R6
  chain_shift_chk: assert property (@(posedge clk) disable iff (rst)
    $past(obs_mode && scan_en && !rst) |-> (chain_q == $past(shl[NG-1:0])));

  // R7
  chain_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!obs_mode && !rst) |-> $stable(chain_q));

  // R8
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (chain_q == '0 && obs_out == 1'b0));
endmodule

bind fb_testpoint_wrap fbw_checker #(
  .NF(NUM_FB), .K(NUM_OBS), .NG(NUM_GRP)
) u_fbw_chk (
  .clk(clk), .rst(rst), .fb_in(fb_in), .tc(tc), .fb_out(fb_out),
  .obs_nets(obs_nets), .obs_mode(obs_mode), .scan_en(scan_en),
  .scan_in(scan_in), .obs_out(obs_out), .chain_q(chain_q)
);

// File: tb/tb_fb_testpoint_wrap.sv
`timescale 1ns/1ps
module tb_fb_testpoint_wrap;
  localparam int NF = 6;
  localparam int K  = 10;
  localparam int NG = (K + 3) / 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NF-1:0] fb_in = '0;
  logic [NF-1:0] tc = '0;
  logic [NF-1:0] fb_out;
  logic [K-1:0]  obs_nets = '0;
  logic          obs_mode = 1'b0;
  logic          scan_en = 1'b0;
  logic          scan_in = 1'b0;
  logic          obs_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  string cur_req = "R8";

  // reference model state
  bit mpar;
  bit mchain [NG];

  always #5 clk = ~clk;

  fb_testpoint_wrap #(.NUM_FB(NF), .NUM_OBS(K)) dut (
    .clk(clk), .rst(rst), .fb_in(fb_in), .tc(tc), .fb_out(fb_out),
    .obs_nets(obs_nets), .obs_mode(obs_mode), .scan_en(scan_en),
    .scan_in(scan_in), .obs_out(obs_out)
  );

  always @(posedge clk) begin
    if (rst) begin
      mpar = 1'b0;
      for (int g = 0; g < NG; g++) mchain[g] = 1'b0;
    end else begin
      bit p;
      p = 1'b0;
      for (int i = 0; i < K; i++) p = p ^ obs_nets[i];
      if (obs_mode) begin
        if (scan_en) begin
          for (int g = NG - 1; g > 0; g--) mchain[g] = mchain[g-1];
          mchain[0] = scan_in;
        end else begin
          for (int g = 0; g < NG; g++) begin
            bit a;
            a = 1'b1;
            for (int j = 0; j < 4; j++)
              a = a & ((4*g + j < K) ? obs_nets[4*g + j] : 1'b1);
            mchain[g] = ~a;
          end
        end
      end
      mpar = p;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit eo;
    eo = obs_mode ? mchain[NG-1] : mpar;
    check(obs_out === eo, cur_req, obs_out, eo);
    check(fb_out === (fb_in ^ tc), "R1", fb_out, fb_in ^ tc);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // reset state, R8
    tick(); tick();
    rst = 1'b0;
    check(obs_out === 1'b0, "R8 tree", obs_out, 0);
    obs_mode = 1'b1; #1;
    check(obs_out === 1'b0, "R8 chain", obs_out, 0);
    obs_mode = 1'b0;
    @(negedge clk);

    // R2: functional mode, observation side active
    cur_req = "R2";
    tc = '0;
    for (int n = 0; n < 8; n++) begin
      fb_in = NF'($urandom); obs_nets = K'($urandom);
      scan_en = $urandom; obs_mode = $urandom;
      #1 check(fb_out === fb_in, "R2", fb_out, fb_in);
      tick();
    end
    // R1: tester drives control bits
    cur_req = "R1";
    for (int n = 0; n < 8; n++) begin
      fb_in = NF'($urandom); tc = NF'($urandom);
      #1 check(fb_out === (fb_in ^ tc), "R1", fb_out, fb_in ^ tc);
      tick();
    end

    // R3: XOR tree
    cur_req = "R3"; obs_mode = 1'b0; scan_en = 1'b0;
    obs_nets = '0; tick();
    check(obs_out === 1'b0, "R3 zeros", obs_out, 0);
    obs_nets = '1; tick();
    check(obs_out === 1'b0, "R3 ones", obs_out, 0);
    for (int i = 0; i < K; i++) begin
      obs_nets = K'(1) << i; tick();
      check(obs_out === 1'b1, "R3 walk", obs_out, 1);
    end
    for (int n = 0; n < 10; n++) begin obs_nets = K'($urandom); tick(); end

    // R4/R5: capture all ones, pad must act as 1
    cur_req = "R4"; obs_mode = 1'b1; scan_en = 1'b0; obs_nets = '1; tick();
    check(obs_out === 1'b0, "R5 pad", obs_out, 0);
    cur_req = "R6"; scan_en = 1'b1; scan_in = 1'b1;
    for (int g = 0; g < NG + 1; g++) tick();
    // capture patterns and shift out
    for (int n = 0; n < 6; n++) begin
      cur_req = "R4"; scan_en = 1'b0;
      obs_nets = (n == 0) ? K'(10'b1011101110) : K'($urandom); tick();
      cur_req = "R6"; scan_en = 1'b1;
      for (int g = 0; g < NG; g++) begin scan_in = $urandom; tick(); end
    end

    // R7: hold while tree selected
    cur_req = "R4"; scan_en = 1'b0; obs_nets = '0; tick();
    cur_req = "R7"; obs_mode = 1'b0;
    for (int n = 0; n < 6; n++) begin
      scan_en = $urandom; scan_in = $urandom; obs_nets = K'($urandom); tick();
    end
    obs_mode = 1'b1; scan_en = 1'b1; scan_in = 1'b0; #1;
    check(obs_out === 1'b1, "R7 held", obs_out, 1);
    for (int g = 0; g < NG; g++) tick();

    // R9: mode toggling
    cur_req = "R9";
    for (int n = 0; n < 30; n++) begin
      obs_mode = $urandom; scan_en = $urandom; scan_in = $urandom;
      obs_nets = K'($urandom); fb_in = NF'($urandom); tc = NF'($urandom);
      #1 compare();
      tick();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule